// File: doc/BRIEF.md
# Activity-Based Powerdown Controller

This block decides when the line driver and receiver stage of a multi-channel serial port may be switched off. It watches every logic-level transmit input and every sliced receive input. When none of them has changed for a programmable number of clock cycles, it drops the interface into automatic powerdown. The first change on any of those lines brings the interface back up.

Two manual pins sit above the automatic logic. An active-low force-off pin always wins and shuts the interface down. A force-on pin, while high, holds the interface up and suspends the inactivity timer. A falling edge on force-on grants a fresh full interval before automatic powerdown can happen. Once the timer has expired, and also after any forced powerdown, the timer stays expired. The interface remains down until a line changes or force-on rises.

The outputs are a powered-up flag, a transmitter output enable, an enable for the standard receiver outputs and a ready-to-transmit flag. The supply-ready input stands in for the analog charge pump reaching its negative rail. All asynchronous inputs pass through two-flop synchronizers. Every latency below counts clock edges from the first rising edge after an input changes.

Top module: `act_pwr_ctl`

## Requirements
- R1: After reset the block is powered up: pwr_up=1, tx_oe=1, rx_oe=1, and tx_ready=0 while supply_ok is low.
- R2: With force_off_n=1 and force_on=0, a change on a tx_in or rx_in bit restarts the interval. If no further change follows, pwr_up is still 1 after edge IDLE_CYCLES+3 and is 0 after edge IDLE_CYCLES+4.
- R3: From automatic powerdown, a change on any single tx_in or rx_in bit sets pwr_up=1 after edge 4, and pwr_up is still 0 after edge 3.
- R4: force_off_n=0 gives pwr_up=0, tx_oe=0 and rx_oe=0 after edge 3, whatever the value of force_on. Line changes while force_off_n is low leave the block down.
- R5: force_on=1 together with force_off_n=1 keeps pwr_up=1 for as long as both are held, with no line activity.
- R6: After a powerdown of either kind, force_off_n returning to 1 while force_on=0 leaves pwr_up=0 with rx_oe=1.
- R7: A rising edge on force_on (with force_off_n=1) wakes the block: pwr_up=1 after edge 3.
- R8: A falling edge on force_on starts a full interval: pwr_up stays 1 through edge IDLE_CYCLES+3 and falls after edge IDLE_CYCLES+4.
- R9: tx_oe is 0 in every powerdown. rx_oe is 0 only in forced powerdown (force_off_n low) and stays 1 in automatic powerdown.
- R10: tx_ready is 0 whenever pwr_up is 0 and falls in the same cycle as pwr_up. While powered up, tx_ready rises after edge 3 following supply_ok going high, and not before.
- R11: The inactivity counter saturates. Automatic powerdown persists with no line change for any length of time.
- R12: A line change whose restart lands in the very cycle the interval would expire wins: the block stays up for a further full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_in | input | N_TX | Logic-level transmit inputs watched for activity |
| rx_in | input | N_RX | Sliced receive inputs watched for activity |
| force_off_n | input | 1 | Active-low manual powerdown, dominant |
| force_on | input | 1 | Manual hold-up; falling edge starts a fresh interval |
| supply_ok | input | 1 | Negative supply rail reached |
| pwr_up | output | 1 | Interface powered up |
| tx_oe | output | 1 | Transmitter output enable |
| rx_oe | output | 1 | Standard receiver output enable |
| tx_ready | output | 1 | Ready to transmit |

## Verification
The restart from a line change and the terminal count of the inactivity counter can fall on the same clock edge. They collide when a second change arrives exactly IDLE_CYCLES cycles after the first. The bench does this on purpose and judges it by requiring pwr_up to be high one cycle after the expiry that the first change alone would have caused, and low a full interval after the second change. Random gaps, some shorter and some longer than the interval, then sweep the region around that boundary.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef enum logic [1:0] {
    PM_UP        = 2'd0,
    PM_AUTO_DN   = 2'd1,
    PM_FORCED_DN = 2'd2
  } pm_mode_t;
endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/apd_edge.sv
module apd_edge #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= d;
  end

  assign chg = d ^ prev_q;
endmodule

// File: rtl/apd_idle_timer.sv
module apd_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic forced,
  input  logic hold_on,
  output logic expired
);
  localparam int unsigned CW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CW-1:0] TERM = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    exp_d  = exp_q;
    cnt_en = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      exp_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (forced) begin
      exp_d  = 1'b1;
    end else if (hold_on) begin
      cnt_d  = '0;
      exp_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (!exp_q) begin
      if (cnt_q == TERM) begin
        exp_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + CW'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/apd_pm_ctl.sv
module apd_pm_ctl
  import apd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic foff_s,
  input  logic fon_s,
  input  logic expired,
  input  logic supply_s,
  output logic pwr_up,
  output logic tx_oe,
  output logic rx_oe,
  output logic tx_ready
);
  pm_mode_t mode_q, mode_d;
  logic     rdy_q, rdy_d;

  always_comb begin
    if (!foff_s)                 mode_d = PM_FORCED_DN;
    else if (fon_s || !expired)  mode_d = PM_UP;
    else                         mode_d = PM_AUTO_DN;
    rdy_d = (mode_d == PM_UP) && supply_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_UP;
      rdy_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rdy_q  <= rdy_d;
    end
  end

  assign pwr_up   = (mode_q == PM_UP);
  assign tx_oe    = (mode_q == PM_UP);
  assign rx_oe    = (mode_q != PM_FORCED_DN);
  assign tx_ready = rdy_q;
endmodule

// File: rtl/act_pwr_ctl.sv
module act_pwr_ctl #(
  parameter int unsigned N_TX        = 3,
  parameter int unsigned N_RX        = 5,
  parameter int unsigned IDLE_CYCLES = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_TX-1:0] tx_in,
  input  logic [N_RX-1:0] rx_in,
  input  logic            force_off_n,
  input  logic            force_on,
  input  logic            supply_ok,
  output logic            pwr_up,
  output logic            tx_oe,
  output logic            rx_oe,
  output logic            tx_ready
);
  localparam int unsigned NL = N_TX + N_RX;
  localparam int unsigned NW = NL + 1;

  logic [NW-1:0] line_s, line_chg;
  logic [1:0]    ctl_s;
  logic          fon_s, foff_s, supply_s;
  logic          any_act, fon_fall, tmr_exp;

  apd_sync #(.W(NW), .RST_VAL('0)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d({force_on, rx_in, tx_in}), .q(line_s)
  );

  apd_edge #(.W(NW), .RST_VAL('0)) u_line_edge (
    .clk(clk), .rst_n(rst_n), .d(line_s), .chg(line_chg)
  );

  apd_sync #(.W(2), .RST_VAL(2'b01)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({supply_ok, force_off_n}), .q(ctl_s)
  );

  assign fon_s    = line_s[NL];
  assign foff_s   = ctl_s[0];
  assign supply_s = ctl_s[1];
  assign any_act  = |line_chg[NL-1:0];
  assign fon_fall = line_chg[NL] & ~fon_s;

  apd_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart(any_act | fon_fall),
    .forced(~foff_s),
    .hold_on(fon_s),
    .expired(tmr_exp)
  );

  apd_pm_ctl u_pm (
    .clk(clk), .rst_n(rst_n),
    .foff_s(foff_s), .fon_s(fon_s), .expired(tmr_exp), .supply_s(supply_s),
    .pwr_up(pwr_up), .tx_oe(tx_oe), .rx_oe(rx_oe), .tx_ready(tx_ready)
  );
endmodule

// File: rtl/apd_checker.sv
module apd_checker (
  input logic clk,
  input logic rst_n,
  input logic foff_s,
  input logic fon_s,
  input logic tmr_exp,
  input logic pwr_up,
  input logic tx_oe,
  input logic rx_oe,
  input logic tx_ready
);
  // R4: a synchronized force-off puts the block in forced powerdown next cycle
  p_force_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !foff_s |=> (!pwr_up && !rx_oe));

  // R5: force-on with force-off released keeps the block up
  p_force_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (foff_s && fon_s) |=> pwr_up);

  // R2: an expired timer in automatic mode means powered down next cycle
  p_auto_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (foff_s && !fon_s && tmr_exp) |=> !pwr_up);

  // R8: falling force-on leaves the block up the following cycle
  p_fon_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fon_s) && foff_s) |=> pwr_up);

  // R9: disabled receivers imply disabled transmitters
  p_rx_off_tx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_oe |-> !tx_oe);

  // R10: ready never shows while powered down
  p_ready_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> pwr_up);
endmodule

bind act_pwr_ctl apd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .foff_s(foff_s), .fon_s(fon_s), .tmr_exp(tmr_exp),
  .pwr_up(pwr_up), .tx_oe(tx_oe), .rx_oe(rx_oe), .tx_ready(tx_ready)
);

// File: tb/act_pwr_ctl_tb.sv
`timescale 1ns/1ps
module act_pwr_ctl_tb;
  localparam int N_TX = 3;
  localparam int N_RX = 5;
  localparam int IDLE = 40;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N_TX-1:0] tx_in;
  logic [N_RX-1:0] rx_in;
  logic            force_off_n, force_on, supply_ok;
  logic            pwr_up, tx_oe, rx_oe, tx_ready;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  act_pwr_ctl #(.N_TX(N_TX), .N_RX(N_RX), .IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .rx_in(rx_in),
    .force_off_n(force_off_n), .force_on(force_on), .supply_ok(supply_ok),
    .pwr_up(pwr_up), .tx_oe(tx_oe), .rx_oe(rx_oe), .tx_ready(tx_ready)
  );

  function automatic bit exp_up_after_gap(int g);
    return (g >= 4) && (g < IDLE + 4);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_state(string tag, bit up, bit rxe, bit rdy);
    chk(tag, "pwr_up", pwr_up, up);
    chk(tag, "tx_oe", tx_oe, up);
    chk(tag, "rx_oe", rx_oe, rxe);
    chk(tag, "tx_ready", tx_ready, rdy);
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic toggle_rand();
    int b = $urandom_range(0, N_TX + N_RX - 1);
    if (b < N_TX) tx_in[b] = ~tx_in[b];
    else          rx_in[b - N_TX] = ~rx_in[b - N_TX];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tx_in = '0; rx_in = '0;
    force_off_n = 1'b1; force_on = 1'b0; supply_ok = 1'b0;
    edges(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1", 1, 1, 0);

    // R10: ready follows supply after three edges
    supply_ok = 1'b1;
    edges(2); chk("R10", "tx_ready early", tx_ready, 1'b0);
    edges(1); chk("R10", "tx_ready", tx_ready, 1'b1);

    // R2: exact timeout; R9 receivers stay enabled in automatic powerdown
    rx_in[0] = ~rx_in[0];
    edges(IDLE + 3); chk_state("R2", 1, 1, 1);
    edges(1);        chk_state("R2", 0, 1, 0);
    chk("R9", "rx_oe auto", rx_oe, 1'b1);

    // R11: stays down, counter does not wrap
    edges(3 * IDLE); chk_state("R11", 0, 1, 0);

    // R3: wake on a transmit-side change
    tx_in[1] = ~tx_in[1];
    edges(3); chk("R3", "pwr_up early", pwr_up, 1'b0);
    edges(1); chk_state("R3", 1, 1, 1);

    // R12: second change restarts exactly at the terminal cycle
    rx_in[2] = ~rx_in[2];
    edges(IDLE);
    rx_in[3] = ~rx_in[3];
    edges(4);        chk("R12", "pwr_up at collision", pwr_up, 1'b1);
    edges(IDLE - 1); chk("R12", "pwr_up end", pwr_up, 1'b1);
    edges(1);        chk("R12", "pwr_up down", pwr_up, 1'b0);

    // R3/R2: random gaps around the interval boundary
    for (int i = 0; i < 16; i++) begin
      int g = 4 + $urandom_range(0, 2 * IDLE);
      toggle_rand();
      edges(g);
      chk("R3", "pwr_up random gap", pwr_up, exp_up_after_gap(g));
      chk("R9", "rx_oe random gap", rx_oe, 1'b1);
    end
    edges(IDLE + 4); chk("R2", "pwr_up settle", pwr_up, 1'b0);

    // R7: rising force-on wakes
    force_on = 1'b1;
    edges(2); chk("R7", "pwr_up early", pwr_up, 1'b0);
    edges(1); chk_state("R7", 1, 1, 1);

    // R5: held up indefinitely
    edges(3 * IDLE); chk_state("R5", 1, 1, 1);

    // R4: force-off dominates force-on and line activity
    force_off_n = 1'b0;
    edges(2); chk("R4", "pwr_up early", pwr_up, 1'b1);
    edges(1); chk_state("R4", 0, 0, 0);
    rx_in[4] = ~rx_in[4];
    edges(5); chk_state("R4", 0, 0, 0);
    chk("R9", "rx_oe forced", rx_oe, 1'b0);

    // R6: releasing force-off with force-on low stays down
    force_on = 1'b0;
    edges(5);
    force_off_n = 1'b1;
    edges(3);        chk_state("R6", 0, 1, 0);
    edges(2 * IDLE); chk_state("R6", 0, 1, 0);

    // R8: falling force-on grants a full interval
    force_on = 1'b1;
    edges(4); chk("R8", "pwr_up held", pwr_up, 1'b1);
    force_on = 1'b0;
    edges(IDLE + 3); chk_state("R8", 1, 1, 1);
    edges(1);        chk_state("R8", 0, 1, 0);

    // R10: wake with supply low, ready only after supply
    supply_ok = 1'b0;
    edges(3);
    rx_in[1] = ~rx_in[1];
    edges(4); chk_state("R10", 1, 1, 0);
    supply_ok = 1'b1;
    edges(2); chk("R10", "tx_ready early", tx_ready, 1'b0);
    edges(1); chk("R10", "tx_ready late", tx_ready, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule